// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital control core of an 8-bit successive-approximation converter that a host drives over a three-wire serial link: a chip select (`cs_n`), a serial clock (`sclk`) and a data line in each direction. Pulling `cs_n` low opens a transaction. The host then clocks in a short command on `din`. The command is a start bit of 1, then a mode bit, then the channel number. The block tracks the selected input for one and a half serial clock periods and then runs an eight-step binary search. During the search it drives a trial code into an external DAC and reads the comparator decision on `cmp_hi`.

Each result bit is shifted out on `dout`, most significant first, as soon as it is decided. The whole word is then sent again least significant first from the same register. A status output `busy` marks the search phase. When `cs_n` is high, both serial outputs are released: their enables go low and the pads are expected to float. Raising `cs_n` also abandons any conversion in progress. All serial lines are sampled by the fast system clock `clk`, so a serial clock phase can last any length of time.

Top module: `sar_serial_ctl`

## Requirements
- R1: `dout_oe` and `busy_oe` are high exactly while `cs_n` is low, and low (high-impedance) while `cs_n` is high.
- R2: Command bits are taken on rising `sclk` edges while `cs_n` is low. Zeros before the first 1 are ignored. After that 1 comes one mode bit, then CHAN_W channel bits, most significant first. `sel_mode` and `sel_chan` present the received values once addressing ends.
- R3: At the first falling `sclk` edge after the last channel bit, `busy` rises, `trial` becomes 1000_0000 and `dout` is low. The first decision is taken one period later, so tracking lasts 1.5 periods after the last addressing rising edge.
- R4: At each of the next eight falling edges, the bit under test in `trial` takes the value of `cmp_hi` (1 keeps it, 0 clears it) and the next lower bit is set. After the eighth decision, `trial` holds the result.
- R5: At each of those eight falling edges, `dout` takes the decision just made, most significant bit first.
- R6: `busy` stays high through the search and falls at the falling edge that decides bit 0.
- R7: On the eight falling edges after the search, `dout` carries result bits 0 through 7 in that order.
- R8: After that, `dout` is low and `trial` keeps the result until `cs_n` rises. Further `sclk` pulses, even with `din` high, start nothing.
- R9: If `cmp_hi` never reports 1, the result is 0000_0000 and every result bit on `dout` is 0.
- R10: A high `cs_n` abandons the transaction. One `clk` later, `busy` is 0 and `trial` is 0. The next low `cs_n` starts a fresh command.
- R11: `dout` changes only at a falling `sclk` edge or on abort. It holds through a serial clock phase of any length.
- R12: After reset, with `cs_n` high, `busy`, `dout` and `trial` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; its falling edge opens a transaction |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial command input |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is at or above `trial` |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Drive enable for `dout` |
| busy | output | 1 | High while the binary search runs |
| busy_oe | output | 1 | Drive enable for `busy` |
| trial | output | DATA_W | Trial code to the DAC; holds the result after the search |
| sel_mode | output | 1 | Received mode bit |
| sel_chan | output | CHAN_W | Received channel number |

## Verification
A wrong bit index or a wrong step counter shows on the next falling `sclk` edge. It appears as a wrong `trial` pattern or a wrong `dout` bit, and a miscounted step also moves the `busy` fall by one serial period. A start-bit hunter that counts a leading zero shifts `sel_mode` and `sel_chan` and moves the first trial by one period. An abort that leaves state behind shows one `clk` after `cs_n` rises, as a nonzero `trial` or a high `busy`.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  typedef enum logic [1:0] {C_HUNT, C_ADDR, C_DONE} cmd_st_e;
  typedef enum logic [2:0] {S_IDLE, S_TRACK, S_CONV, S_SEND, S_HOLD} sar_st_e;
endpackage

// File: rtl/sclk_edge.sv
module sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/cmd_rx.sv
module cmd_rx
  import sar_ctl_pkg::*;
#(
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              rise,
  input  logic              din,
  output logic              start,
  output logic              sel_mode,
  output logic [CHAN_W-1:0] sel_chan
);
  localparam int NB = CHAN_W + 1;
  localparam int CW = $clog2(NB + 1);

  cmd_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NB-1:0] sh_q, sh_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    start = 1'b0;
    if (abort) begin
      st_d  = C_HUNT;
      cnt_d = '0;
    end else begin
      case (st_q)
        C_HUNT: if (rise && din) begin
          st_d  = C_ADDR;
          cnt_d = '0;
        end
        C_ADDR: if (rise) begin
          sh_d  = {sh_q[NB-2:0], din};
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == CW'(NB - 1)) begin
            st_d  = C_DONE;
            start = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_HUNT;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign sel_mode = sh_q[NB-1];
  assign sel_chan = sh_q[CHAN_W-1:0];

  // R2: a zero seen while hunting leaves the hunter where it was
  p_lead_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_HUNT && rise && !din && !abort) |=> st_q == C_HUNT);

  // R8: once addressing is over, only an abort leaves the done state
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_DONE && !abort) |=> st_q == C_DONE);
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              fall,
  input  logic              cmp_hi,
  output logic              dout,
  output logic              busy,
  output logic [DATA_W-1:0] trial
);
  localparam int IW = $clog2(DATA_W);

  sar_st_e           st_q, st_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] trial_q, trial_d;
  logic              dout_q, dout_d;
  logic              busy_q, busy_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    trial_d = trial_q;
    dout_d  = dout_q;
    busy_d  = busy_q;
    if (abort) begin
      st_d    = S_IDLE;
      idx_d   = '0;
      trial_d = '0;
      dout_d  = 1'b0;
      busy_d  = 1'b0;
    end else begin
      case (st_q)
        S_IDLE:  if (start) st_d = S_TRACK;
        S_TRACK: if (fall) begin
          trial_d             = '0;
          trial_d[DATA_W-1]   = 1'b1;
          dout_d              = 1'b0;
          busy_d              = 1'b1;
          idx_d               = IW'(DATA_W - 1);
          st_d                = S_CONV;
        end
        S_CONV: if (fall) begin
          trial_d[idx_q] = cmp_hi;
          dout_d         = cmp_hi;
          if (idx_q == '0) begin
            busy_d = 1'b0;
            st_d   = S_SEND;
          end else begin
            trial_d[idx_q - IW'(1)] = 1'b1;
            idx_d                   = idx_q - IW'(1);
          end
        end
        S_SEND: if (fall) begin
          dout_d = trial_q[idx_q];
          if (idx_q == IW'(DATA_W - 1)) st_d = S_HOLD;
          else                          idx_d = idx_q + IW'(1);
        end
        S_HOLD: if (fall) dout_d = 1'b0;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      trial_q <= '0;
      dout_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      trial_q <= trial_d;
      dout_q  <= dout_d;
      busy_q  <= busy_d;
    end
  end

  assign dout  = dout_q;
  assign busy  = busy_q;
  assign trial = trial_q;

  p_track_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TRACK && fall && !abort) |=> (busy_q && trial_q == {1'b1, {(DATA_W-1){1'b0}}}));

  p_keep_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CONV && fall && !abort) |=> trial_q[$past(idx_q)] == $past(cmp_hi));

  p_dout_decision_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CONV && fall && !abort) |=> dout_q == $past(cmp_hi));

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(abort) || ($past(st_q) == S_CONV && $past(idx_q) == '0)));

  p_abort_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy_q && trial_q == '0 && st_q == S_IDLE));

  p_dout_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_q) |-> ($past(fall) || $past(abort)));
endmodule

// File: rtl/sar_serial_ctl.sv
module sar_serial_ctl #(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              cmp_hi,
  output logic              dout,
  output logic              dout_oe,
  output logic              busy,
  output logic              busy_oe,
  output logic [DATA_W-1:0] trial,
  output logic              sel_mode,
  output logic [CHAN_W-1:0] sel_chan
);
  logic rst_meta, rst_sync;
  logic rise, fall, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sclk_edge u_edge (
    .clk   (clk),
    .rst_n (rst_sync),
    .sclk  (sclk),
    .rise  (rise),
    .fall  (fall)
  );

  cmd_rx #(.CHAN_W(CHAN_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_sync),
    .abort    (cs_n),
    .rise     (rise),
    .din      (din),
    .start    (start),
    .sel_mode (sel_mode),
    .sel_chan (sel_chan)
  );

  sar_core #(.DATA_W(DATA_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_sync),
    .abort  (cs_n),
    .start  (start),
    .fall   (fall),
    .cmp_hi (cmp_hi),
    .dout   (dout),
    .busy   (busy),
    .trial  (trial)
  );

  assign dout_oe = ~cs_n;
  assign busy_oe = ~cs_n;
endmodule

// File: tb/sar_serial_ctl_test.sv
module sar_serial_ctl_test;
  localparam int DW = 8;
  localparam int CW = 3;
  localparam int K_DOUT = 0, K_BUSY = 1, K_TRIAL = 2, K_MODE = 3,
                 K_CHAN = 4, K_DOE = 5, K_BOE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b0;
  logic          din = 1'b0;
  logic [DW-1:0] vin = '0;
  logic          force_lo = 1'b0;
  logic          cmp_hi;
  logic          dout, dout_oe, busy, busy_oe, sel_mode;
  logic [DW-1:0] trial;
  logic [CW-1:0] sel_chan;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {int kind; int req; int exp;} item_t;
  item_t q[$];
  event  sample_ev;

  always #2.5 clk = ~clk;

  // behavioural DAC and comparator
  assign cmp_hi = force_lo ? 1'b0 : (vin >= trial);

  sar_serial_ctl #(.DATA_W(DW), .CHAN_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cmp_hi(cmp_hi), .dout(dout), .dout_oe(dout_oe), .busy(busy),
    .busy_oe(busy_oe), .trial(trial), .sel_mode(sel_mode), .sel_chan(sel_chan)
  );

  function automatic int actual(int kind);
    case (kind)
      K_DOUT:  return int'(dout);
      K_BUSY:  return int'(busy);
      K_TRIAL: return int'(trial);
      K_MODE:  return int'(sel_mode);
      K_CHAN:  return int'(sel_chan);
      K_DOE:   return int'(dout_oe);
      default: return int'(busy_oe);
    endcase
  endfunction

  task automatic expect_val(int kind, int req, int exp);
    item_t it;
    it.kind = kind; it.req = req; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic flush();
    ->sample_ev;
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares with the ports
  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (actual(it.kind) != it.exp) begin
        fails++;
        $display("FAIL R%0d kind %0d: actual %0d expected %0d at %0t",
                 it.req, it.kind, actual(it.kind), it.exp, $time);
      end
    end
  end

  // one serial pulse; returns one clk after the falling edge
  task automatic pulse(input logic b, input int h);
    din  = b;
    sclk = 1'b1;
    repeat (h) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  // flush the checks of this edge, hold low, confirm dout held (R11)
  task automatic settle(input int h, input int dexp);
    flush();
    repeat (h) @(negedge clk);
    expect_val(K_DOUT, 11, dexp); // R11
    flush();
  endtask

  task automatic release_cs();
    cs_n = 1'b1;
    din  = 1'b0;
    @(negedge clk);
    expect_val(K_DOE, 1, 0);  // R1
    expect_val(K_BOE, 1, 0);  // R1
    expect_val(K_BUSY, 10, 0); // R10
    expect_val(K_TRIAL, 10, 0); // R10
    flush();
  endtask

  task automatic conv(input logic [DW-1:0] v, input bit lo, input logic md,
                      input logic [CW-1:0] ch, input int nz, input int h,
                      input int abort_at);
    logic [DW-1:0] ev;
    int            ndec;
    vin      = v;
    force_lo = lo;
    ev       = lo ? '0 : v;
    ndec     = 0;
    cs_n     = 1'b0;
    repeat (2) @(negedge clk);
    expect_val(K_DOE, 1, 1); // R1
    expect_val(K_BOE, 1, 1); // R1
    flush();
    for (int i = 0; i < nz; i++) begin
      pulse(1'b0, h);
      expect_val(K_BUSY, 2, 0); // R2 leading zero ignored
      settle(h, 0);
    end
    pulse(1'b1, h);
    expect_val(K_BUSY, 2, 0); // R2
    settle(h, 0);
    pulse(md, h);
    expect_val(K_BUSY, 3, 0); // R3 no search during addressing
    settle(h, 0);
    for (int b = CW - 1; b >= 0; b--) begin
      pulse(ch[b], h);
      if (b == 0) begin
        expect_val(K_MODE, 2, int'(md)); // R2
        expect_val(K_CHAN, 2, int'(ch)); // R2
        expect_val(K_BUSY, 3, 1);        // R3
        expect_val(K_TRIAL, 3, 8'h80);   // R3
        expect_val(K_DOUT, 3, 0);        // R3
      end else begin
        expect_val(K_BUSY, 2, 0);        // R2
      end
      settle(h, 0);
    end
    for (int i = DW - 1; i >= 0; i--) begin
      logic [DW-1:0] te;
      te = ev & (8'hFF << i);
      if (i > 0) te[i-1] = 1'b1;
      pulse(1'b0, h);
      expect_val(K_DOUT, lo ? 9 : 5, int'(ev[i])); // R5 / R9
      expect_val(K_TRIAL, 4, int'(te));            // R4
      expect_val(K_BUSY, 6, (i != 0) ? 1 : 0);     // R6
      settle(h, int'(ev[i]));
      ndec++;
      if (ndec == abort_at) begin
        release_cs();
        return;
      end
    end
    for (int j = 0; j < DW; j++) begin
      pulse(1'b0, h);
      expect_val(K_DOUT, lo ? 9 : 7, int'(ev[j])); // R7 / R9
      expect_val(K_BUSY, 7, 0);                    // R7
      settle(h, int'(ev[j]));
    end
    for (int k = 0; k < 2; k++) begin
      pulse(1'b1, h);
      expect_val(K_DOUT, 8, 0);         // R8
      expect_val(K_BUSY, 8, 0);         // R8
      expect_val(K_TRIAL, 8, int'(ev)); // R8
      settle(h, 0);
    end
    release_cs();
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_val(K_BUSY, 12, 0);  // R12
    expect_val(K_TRIAL, 12, 0); // R12
    expect_val(K_DOUT, 12, 0);  // R12
    expect_val(K_DOE, 1, 0);    // R1
    expect_val(K_BOE, 1, 0);    // R1
    flush();

    conv(8'hA5, 1'b0, 1'b1, 3'd5, 0, 3, -1);
    conv(8'h3C, 1'b0, 1'b0, 3'd2, 3, 2, -1);   // R2 leading zeros
    conv(8'hFF, 1'b0, 1'b1, 3'd7, 1, 3, -1);
    conv(8'h00, 1'b0, 1'b0, 3'd0, 0, 3, -1);   // R9 comparator never high
    conv(8'hC8, 1'b1, 1'b1, 3'd3, 0, 3, -1);   // R9 forced low
    conv(8'h81, 1'b0, 1'b0, 3'd6, 2, 3, 3);    // R10 abort mid-search
    conv(8'h5A, 1'b0, 1'b1, 3'd1, 0, 3, -1);   // R10 fresh start after abort
    conv(8'h69, 1'b0, 1'b0, 3'd4, 1, 1500, -1); // R11 long phases

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule